// File: doc/BRIEF.md
# Set-Associative Tag Store with Line Reservation

This block keeps the tag and per-line state for a parameterised set-associative cache. It answers one lookup per clock. Each lookup returns one of four outcomes. A hit means a usable line holds the block. A pending hit means the line's fill has not yet returned. A miss means the block claims a victim line and reports that line's index. A reservation failure means every way of the addressed set is waiting on a fill. When the claimed victim holds dirty data, the response also carries a writeback flag and the victim's block address, so the caller can push the old contents out. A separate fill port turns an outstanding line into a usable one. A single-cycle flush clears the whole store.

Lookups enter on a valid/ready pair. `lk_ready` falls only in a cycle where `flush` is high. A lookup offered in that cycle is not taken, and the caller holds `lk_valid` and the request until the handshake completes. The response comes out of registers one cycle after acceptance, as a one-cycle `rsp_valid` pulse. It has no ready: the consumer must take it when it appears. Replacement is chosen at build time. It is either least-recently-used, with a timestamp refreshed on hits and fills, or first-in-first-out, with a timestamp written only at allocation. Two running counters report lookups and misses.

Top module: `cache_tag_store`

## Requirements
- R1: After reset `rsp_valid` is 0, both counters are 0, `lk_ready` is 1 and every line is empty, so the first lookup of any address is a miss.
- R2: A lookup is taken in a cycle where `lk_valid` and `lk_ready` are both 1. `lk_ready` is 0 exactly in cycles with `flush` high. Each taken lookup gives one `rsp_valid` pulse in the next cycle, and no pulse appears without one.
- R3: `rsp_status` encoding: 0 is hit, 1 is pending hit, 2 is miss, 3 is reservation failure. A tag match on a line awaiting its fill gives 1 and that line's index. A match on a usable clean or dirty line gives 0. An empty line never matches.
- R4: When every way of the set is awaiting a fill and no way matches, the result is 3 with index 0, and no line changes.
- R5: The miss victim is the lowest-numbered empty way. If there is none, it is the usable way with the smallest timestamp, and ties go to the lower way. With `REPL_FIFO`=0 the timestamp is the time of last use (allocation, hit or fill). With `REPL_FIFO`=1 it is the allocation time only.
- R6: A miss (2) marks the victim as awaiting a fill with the new tag and reports line index = set × `WAYS` + way.
- R7: If the miss victim was dirty, `rsp_wb` is 1 and `rsp_wb_addr` is that line's old block address (old tag, same set, zero offset). Otherwise `rsp_wb` is 0.
- R8: A hit with `lk_write`=1 makes the line dirty. A pending hit changes nothing.
- R9: A fill of a line awaiting its fill makes it usable and clean, and in LRU mode stamps its last-use time. A fill of any other line has no effect.
- R10: `flush` empties every line in one cycle and overrides a fill in the same cycle.
- R11: `acc_count` adds 1 for each taken lookup. `miss_count` adds 1 for each result 2 or 3.
- R12: When a fill and a lookup fall in the same cycle, the lookup sees the state from before the fill, and the fill still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be taken this cycle |
| lk_addr | input | ADDR_W | Byte address of the lookup |
| lk_write | input | 1 | Lookup is a store; a hit marks the line dirty |
| rsp_valid | output | 1 | Response pulse, one cycle after a taken lookup |
| rsp_status | output | 2 | Outcome code (see R3) |
| rsp_index | output | log2(NUM_SETS*WAYS) | Line index of the hit or victim line |
| rsp_wb | output | 1 | Victim was dirty and must be written back |
| rsp_wb_addr | output | ADDR_W | Block address of the dirty victim |
| fill_en | input | 1 | Fill completion strobe |
| fill_idx | input | log2(NUM_SETS*WAYS) | Line index of the completed fill |
| flush | input | 1 | Empty all lines this cycle |
| acc_count | output | CNT_W | Taken lookups since reset |
| miss_count | output | CNT_W | Misses and reservation failures since reset |

## Verification
Two functions can collide in one cycle: a fill completing and a lookup reading the same set. The bench reserves a line, then in a single cycle drives the fill for that line together with a lookup of its address. It expects a pending-hit result from that lookup and a plain hit from the next one. It also offers a lookup in a flush cycle, and expects `lk_ready` low, no response and an unchanged access counter. The replacement choice is judged by driving identical stimulus into an LRU instance and a FIFO instance. After a hit refreshes only the older line, the two must pick different victims.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_RSV = 2'd1,
    LS_VAL = 2'd2,
    LS_MOD = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    RS_HIT     = 2'd0,
    RS_HIT_RSV = 2'd1,
    RS_MISS    = 2'd2,
    RS_FAIL    = 2'd3
  } res_e;
endpackage

// File: rtl/ctag_match.sv
module ctag_match
  import ctag_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][1:0]      way_st,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]          lk_tag,
  output logic [WAYS-1:0]           match_vec,
  output logic [WAY_W-1:0]          hit_way
);
  // one comparator per way; empty lines never match
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = (way_tag[w] == lk_tag) && (way_st[w] != LS_INV);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ctag_victim.sv
module ctag_victim
  import ctag_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int TS_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][1:0]      way_st,
  input  logic [WAYS-1:0][TS_W-1:0] way_ts,
  output logic                      all_rsv,
  output logic [WAY_W-1:0]          vic_way
);
  logic             found_inv, found_old;
  logic [WAY_W-1:0] inv_way, old_way;
  logic [TS_W-1:0]  best_ts;

  always_comb begin
    all_rsv   = 1'b1;
    found_inv = 1'b0;
    found_old = 1'b0;
    inv_way   = '0;
    old_way   = '0;
    best_ts   = '1;
    for (int w = 0; w < WAYS; w++) begin
      if (way_st[w] != LS_RSV) all_rsv = 1'b0;
      if (way_st[w] == LS_INV) begin
        if (!found_inv) begin
          found_inv = 1'b1;
          inv_way   = WAY_W'(w);
        end
      end else if (way_st[w] != LS_RSV) begin
        // strict compare keeps the lower way on a tie
        if (!found_old || (way_ts[w] < best_ts)) begin
          found_old = 1'b1;
          best_ts   = way_ts[w];
          old_way   = WAY_W'(w);
        end
      end
    end
    vic_way = found_inv ? inv_way : old_way;
  end
endmodule

// File: rtl/ctag_counters.sv
module ctag_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_acc,
  input  logic             inc_miss,
  output logic [CNT_W-1:0] acc_count,
  output logic [CNT_W-1:0] miss_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_count  <= '0;
      miss_count <= '0;
    end else begin
      if (inc_acc)  acc_count  <= acc_count + 1'b1;
      if (inc_miss) miss_count <= miss_count + 1'b1;
    end
  end

  AST_MISS_LE_ACC: assert property (@(posedge clk) disable iff (rst)
    miss_count <= acc_count); // R11

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    (acc_count - $past(acc_count)) <= CNT_W'(1)); // R11
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store
  import ctag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_SETS   = 16,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 64,
  parameter int TS_W       = 16,
  parameter int CNT_W      = 32,
  parameter bit REPL_FIFO  = 1'b0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              lk_valid,
  output logic                              lk_ready,
  input  logic [ADDR_W-1:0]                 lk_addr,
  input  logic                              lk_write,
  output logic                              rsp_valid,
  output logic [1:0]                        rsp_status,
  output logic [$clog2(NUM_SETS*WAYS)-1:0]  rsp_index,
  output logic                              rsp_wb,
  output logic [ADDR_W-1:0]                 rsp_wb_addr,
  input  logic                              fill_en,
  input  logic [$clog2(NUM_SETS*WAYS)-1:0]  fill_idx,
  input  logic                              flush,
  output logic [CNT_W-1:0]                  acc_count,
  output logic [CNT_W-1:0]                  miss_count
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int LINES = NUM_SETS * WAYS;
  localparam int IDX_W = $clog2(LINES);
  // LRU refreshes the stamp on every use, FIFO only at allocation
  localparam bit STAMP_ON_USE = !REPL_FIFO;

  line_st_e        st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [TS_W-1:0]  ts_q  [LINES];
  logic [TS_W-1:0]  now_q;

  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic             unused_off;

  assign lk_set     = lk_addr[OFF_W +: SET_W];
  assign lk_tag     = lk_addr[ADDR_W-1 -: TAG_W];
  assign unused_off = ^lk_addr[OFF_W-1:0];

  // gather the addressed set
  logic [WAYS-1:0][1:0]       set_st;
  logic [WAYS-1:0][TAG_W-1:0] set_tag;
  logic [WAYS-1:0][TS_W-1:0]  set_ts;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_st[w]  = st_q[{lk_set, WAY_W'(w)}];
      set_tag[w] = tag_q[{lk_set, WAY_W'(w)}];
      set_ts[w]  = ts_q[{lk_set, WAY_W'(w)}];
    end
  end

  logic [WAYS-1:0]  match_vec;
  logic [WAY_W-1:0] hit_way, vic_way;
  logic             hit, all_rsv;

  ctag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_st    (set_st),
    .way_tag   (set_tag),
    .lk_tag    (lk_tag),
    .match_vec (match_vec),
    .hit_way   (hit_way)
  );

  ctag_victim #(.WAYS(WAYS), .TS_W(TS_W)) u_victim (
    .way_st  (set_st),
    .way_ts  (set_ts),
    .all_rsv (all_rsv),
    .vic_way (vic_way)
  );

  assign hit = |match_vec;

  res_e             res;
  logic [IDX_W-1:0] hit_idx, vic_idx;
  logic             vic_dirty, accept;

  assign lk_ready  = !flush;
  assign accept    = lk_valid && lk_ready;
  assign hit_idx   = {lk_set, hit_way};
  assign vic_idx   = {lk_set, vic_way};
  assign vic_dirty = (set_st[vic_way] == LS_MOD);

  always_comb begin
    if (hit)          res = (set_st[hit_way] == LS_RSV) ? RS_HIT_RSV : RS_HIT;
    else if (all_rsv) res = RS_FAIL;
    else              res = RS_MISS;
  end

  // response registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_status  <= 2'd0;
      rsp_index   <= '0;
      rsp_wb      <= 1'b0;
      rsp_wb_addr <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_status <= res;
        unique case (res)
          RS_HIT, RS_HIT_RSV: rsp_index <= hit_idx;
          RS_MISS:            rsp_index <= vic_idx;
          default:            rsp_index <= '0;
        endcase
        rsp_wb      <= (res == RS_MISS) && vic_dirty;
        rsp_wb_addr <= ((res == RS_MISS) && vic_dirty)
                       ? {set_tag[vic_way], lk_set, {OFF_W{1'b0}}} : '0;
      end
    end
  end

  // line state, tags and timestamps
  always_ff @(posedge clk) begin
    if (rst) begin
      now_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LS_INV;
        tag_q[i] <= '0;
        ts_q[i]  <= '0;
      end
    end else begin
      now_q <= now_q + 1'b1;
      if (flush) begin
        for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
      end else begin
        if (fill_en && (st_q[fill_idx] == LS_RSV)) begin
          st_q[fill_idx] <= LS_VAL;
          if (STAMP_ON_USE) ts_q[fill_idx] <= now_q;
        end
        if (accept) begin
          if (res == RS_HIT) begin
            if (STAMP_ON_USE) ts_q[hit_idx] <= now_q;
            if (lk_write) st_q[hit_idx] <= LS_MOD;
          end else if (res == RS_MISS) begin
            st_q[vic_idx]  <= LS_RSV;
            tag_q[vic_idx] <= lk_tag;
            ts_q[vic_idx]  <= now_q;
          end
        end
      end
    end
  end

  ctag_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .inc_acc    (accept),
    .inc_miss   (accept && ((res == RS_MISS) || (res == RS_FAIL))),
    .acc_count  (acc_count),
    .miss_count (miss_count)
  );

  logic any_live;
  always_comb begin
    any_live = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (st_q[i] != LS_INV) any_live = 1'b1;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec)); // R3

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit && !all_rsv) |-> (set_st[vic_way] != LS_RSV)); // R5

  AST_WB_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_wb) |-> (rsp_status == RS_MISS)); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !any_live); // R10

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lk_valid && !flush)); // R2
endmodule

// File: tb/sim_cache_tag_store.sv
module sim_cache_tag_store;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_write = 1'b0, fill_en = 1'b0, flush = 1'b0;
  logic [15:0] lk_addr = '0;
  logic [2:0]  fill_idx = '0;

  logic        lk_ready, rsp_valid, rsp_wb;
  logic [1:0]  rsp_status;
  logic [2:0]  rsp_index;
  logic [15:0] rsp_wb_addr;
  logic [31:0] acc_count, miss_count;

  logic        lk_ready_f, rsp_valid_f, rsp_wb_f;
  logic [1:0]  rsp_status_f;
  logic [2:0]  rsp_index_f;
  logic [15:0] rsp_wb_addr_f;
  logic [31:0] acc_count_f, miss_count_f;

  always #2 clk = ~clk; // 250 MHz

  cache_tag_store #(.ADDR_W(16), .NUM_SETS(4), .WAYS(2), .LINE_BYTES(16),
                    .TS_W(16), .CNT_W(32), .REPL_FIFO(1'b0)) u0 (
    .clk, .rst, .lk_valid, .lk_ready, .lk_addr, .lk_write,
    .rsp_valid, .rsp_status, .rsp_index, .rsp_wb, .rsp_wb_addr,
    .fill_en, .fill_idx, .flush, .acc_count, .miss_count);

  cache_tag_store #(.ADDR_W(16), .NUM_SETS(4), .WAYS(2), .LINE_BYTES(16),
                    .TS_W(16), .CNT_W(32), .REPL_FIFO(1'b1)) u1 (
    .clk, .rst, .lk_valid, .lk_ready(lk_ready_f), .lk_addr, .lk_write,
    .rsp_valid(rsp_valid_f), .rsp_status(rsp_status_f), .rsp_index(rsp_index_f),
    .rsp_wb(rsp_wb_f), .rsp_wb_addr(rsp_wb_addr_f),
    .fill_en, .fill_idx, .flush, .acc_count(acc_count_f), .miss_count(miss_count_f));

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // address map: tag = addr[15:6], set = addr[5:4]; lines of set 1 are 2 and 3
  localparam logic [15:0] A = 16'h0010, B = 16'h0050, C = 16'h0090, D = 16'h00D0;
  localparam logic [15:0] P = 16'h0000, Q = 16'h0040, R = 16'h0080;

  function automatic logic [43:0] v(input logic [1:0] op, input logic [15:0] a,
      input logic wr, input logic [2:0] fi, input logic [1:0] es,
      input logic [2:0] ei, input logic ew, input logic [15:0] ea);
    return {op, a, wr, fi, es, ei, ew, ea};
  endfunction

  // op 0 lookup, 1 fill; expected status 0 hit,1 pending,2 miss,3 fail
  localparam int NV = 14;
  localparam logic [43:0] VEC [NV] = '{
    v(0, A, 0, 0, 2, 2, 0, 0),      // R1 empty store: miss, way0
    v(0, A, 0, 0, 1, 2, 0, 0),      // R3 pending hit
    v(0, B, 0, 0, 2, 3, 0, 0),      // R5 second empty way
    v(0, C, 0, 0, 3, 0, 0, 0),      // R4 both ways pending
    v(1, 0, 0, 2, 0, 0, 0, 0),      // R9 fill line 2
    v(0, C, 0, 0, 2, 2, 0, 0),      // R5 only usable way
    v(1, 0, 0, 2, 0, 0, 0, 0),
    v(1, 0, 0, 3, 0, 0, 0, 0),
    v(0, B, 1, 0, 0, 3, 0, 0),      // R8 write hit -> dirty
    v(0, C, 0, 0, 0, 2, 0, 0),      // R3 hit refreshes line 2
    v(1, 0, 0, 3, 0, 0, 0, 0),      // R9 fill of dirty line: no effect
    v(0, D, 0, 0, 2, 3, 1, 16'h0050), // R7 dirty victim written back
    v(1, 0, 0, 3, 0, 0, 0, 0),
    v(0, A, 0, 0, 2, 2, 0, 0)       // R5 LRU picks line 2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [15:0] a,
                       input logic wr, input logic [2:0] fi);
    @(negedge clk);
    lk_valid = (op == 2'd0);
    lk_addr  = a;
    lk_write = wr;
    fill_en  = (op == 2'd1);
    fill_idx = fi;
    flush    = (op == 2'd2);
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
    lk_write = 1'b0;
    fill_en  = 1'b0;
    flush    = 1'b0;
  endtask

  function automatic string tag_of(input logic [1:0] s);
    case (s)
      2'd0:    return "R3 hit status";
      2'd1:    return "R3 pending-hit status";
      2'd2:    return "R6 miss status";
      default: return "R4 reservation-fail status";
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 acc_count after reset", acc_count, 0);
    chk("R1 miss_count after reset", miss_count, 0);
    chk("R1 lk_ready after reset", lk_ready, 1);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] e;
      e = VEC[i];
      do_op(e[43:42], e[41:26], e[25], e[24:22]);
      if (e[43:42] == 2'd0) begin
        chk("R2 response pulse", rsp_valid, 1);
        chk(tag_of(e[21:20]), rsp_status, e[21:20]);
        chk("R5 R6 line index", rsp_index, e[19:17]);
        chk("R7 R8 R9 writeback flag", rsp_wb, e[16]);
        if (e[16]) chk("R7 writeback address", rsp_wb_addr, e[15:0]);
      end else begin
        chk("R2 no response without lookup", rsp_valid, 0);
      end
    end

    chk("R11 access count", acc_count, 9);
    chk("R11 miss count", miss_count, 6);

    // flush with a lookup offered in the same cycle
    @(negedge clk);
    flush = 1'b1; lk_valid = 1'b1; lk_addr = A;
    #1;
    chk("R2 R10 lk_ready low during flush", lk_ready, 0);
    @(posedge clk);
    #1;
    flush = 1'b0; lk_valid = 1'b0;
    chk("R2 no response for refused lookup", rsp_valid, 0);
    chk("R11 refused lookup not counted", acc_count, 9);

    // D was resident before the flush: must miss now
    do_op(0, D, 0, 0);
    chk("R10 flushed line does not hit", rsp_status, 2);
    chk("R10 victim is lowest empty way", rsp_index, 2);

    // fill and lookup of the same line in one cycle
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = D; fill_en = 1'b1; fill_idx = 3'd2;
    @(posedge clk);
    #1;
    lk_valid = 1'b0; fill_en = 1'b0;
    chk("R12 lookup sees pre-fill state", rsp_status, 1);
    chk("R12 pending-hit index", rsp_index, 2);
    do_op(0, D, 0, 0);
    chk("R12 fill took effect", rsp_status, 0);

    // flush overrides a fill issued in the same cycle
    do_op(0, A, 0, 0); // line 3 now pending
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_idx = 3'd3;
    @(posedge clk);
    #1;
    flush = 1'b0; fill_en = 1'b0;
    do_op(0, A, 0, 0);
    chk("R10 flush wins over fill", rsp_status, 2);

    // replacement policy: LRU instance u0 vs FIFO instance u1
    do_op(2, 0, 0, 0);
    do_op(0, P, 0, 0);
    chk("R6 FIFO unit first miss index", rsp_index_f, 0);
    do_op(0, Q, 0, 0);
    chk("R6 FIFO unit second miss index", rsp_index_f, 1);
    do_op(1, 0, 0, 0);
    do_op(1, 0, 0, 1);
    do_op(0, P, 0, 0);
    chk("R3 FIFO unit hit", rsp_status_f, 0);
    do_op(0, R, 0, 0);
    chk("R5 LRU victim is least recently used", rsp_index, 1);
    chk("R5 FIFO victim is oldest allocation", rsp_index_f, 0);
    chk("R6 FIFO unit miss status", rsp_status_f, 2);

    finish_run();
  end
endmodule